// File: doc/BRIEF.md
# Multi-Mode Timer/Event Counter

This peripheral holds a 16-bit up-counter behind a small byte-wide register bus. The counter can count active edges on an external pin, count cycles in which an internal tick is high, or measure how long the pin stays at a chosen level. An 8-bit control register selects the mode, the pin polarity and the count enable. The count is read as a low byte and a high byte. Counting is suspended for any cycle in which the high byte is being read, so an increment that falls in that cycle is lost.

Writes to the two count addresses set a 16-bit reload value. The counter takes that value at once only while counting is disabled. When the counter wraps from all ones it restarts from the reload value and raises a one-cycle overflow pulse. In pulse-width mode the block clears its own enable bit when the pulse ends, so the measured width stays in the counter until software reads it.

Top module: `evt_timer`

## Requirements
- R1: After reset the control register reads 0x00, both count bytes read 0x00 and `ovf_o` is low.
- R2: Address 0 is the control register. Bits 7:6 are the mode, bit 4 is the count enable and bit 3 is the polarity. Bits 5 and 2:0 always read 0, so a write of 0xFF reads back as 0xD8. Address 3 reads 0, and `rdata_o` is 0 whenever `rd_i` is low.
- R3: In tick mode (mode 2'b10) with the enable set, the counter increases by one on every clock in which `tick_i` is high. With the enable clear it holds its value.
- R4: In edge mode (mode 2'b01) with polarity 0, the counter increases once for each rising edge of `pin_i`.
- R5: In edge mode with polarity 1, the counter increases once for each falling edge of `pin_i`, and rising edges are not counted.
- R6: In mode 2'b00 the counter never changes on ticks or pin edges, even with the enable set.
- R7: In pulse-width mode (mode 2'b11) with polarity 0, the counter increases on each tick while the synchronized pin is high. When the pin falls, the enable bit clears and the value holds. Later pulses do not change it.
- R8: In pulse-width mode with polarity 1, the counter increases on each tick while the pin is low. The enable bit clears when the pin rises.
- R9: When the counter steps from 0xFFFF, the next value is the reload value. `ovf_o` is high for exactly the one cycle after that step.
- R10: A write to address 1 sets the low byte of the reload value, and a write to address 2 sets its high byte. While the enable is clear, the same write also loads that byte into the counter. While the enable is set, the counter is not changed by the write.
- R11: A count step does not happen in a cycle where `rd_i` is high and `addr_i` is 2. That increment is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address: 0 control, 1 count low, 2 count high |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | Read strobe. A read of address 2 blocks counting for that cycle |
| rdata_o | output | 8 | Read data, combinational, zero when idle |
| pin_i | input | 1 | External pin, asynchronous |
| tick_i | input | 1 | Internal count enable tick |
| ovf_o | output | 1 | One-cycle overflow pulse |

## Verification
A wrong control state shows at once in a control read: a bit that should read zero reads one, or the enable bit fails to clear after a pulse. A wrong counter state shows in the next two-byte read, and every scenario makes that read within a few cycles of its last stimulus. Synchronizer or edge-selection faults appear as a count that is off by whole pulses. A freeze fault shows as one extra increment. A reload or overflow fault shows in the cycle right after the wrap, both on `ovf_o` and in the value that follows 0xFFFF.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_EVT = 2'b01,
    MODE_TIM = 2'b10,
    MODE_PW  = 2'b11
  } tmr_mode_e;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_CNT_LO = 2'd1;
  localparam logic [1:0] ADDR_CNT_HI = 2'd2;

  localparam int unsigned CTRL_POL_BIT = 3;
  localparam int unsigned CTRL_EN_BIT  = 4;
  localparam int unsigned CTRL_MODE_LO = 6;
endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic pol_i,
  output logic lvl_o,
  output logic hit_o,
  output logic trail_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[s] <= 1'b0;
          else         sync_q[s] <= pin_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[s] <= 1'b0;
          else         sync_q[s] <= sync_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];

  logic rise, fall;
  assign lvl_o   = sync_q[STAGES-1];
  assign rise    = lvl_o & ~prev_q;
  assign fall    = ~lvl_o & prev_q;
  // active edge for event mode; opposite edge ends a pulse
  assign hit_o   = pol_i ? fall : rise;
  assign trail_o = pol_i ? rise : fall;
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          clr_en_i,
  output tmr_mode_e     mode_o,
  output logic          en_o,
  output logic          pol_o,
  output logic [DW-1:0] ctrl_o
);
  tmr_mode_e mode_q;
  logic      en_q, pol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
      en_q   <= 1'b0;
      pol_q  <= 1'b0;
    end else if (wr_i) begin
      mode_q <= tmr_mode_e'(wdata_i[CTRL_MODE_LO +: 2]);
      en_q   <= wdata_i[CTRL_EN_BIT];
      pol_q  <= wdata_i[CTRL_POL_BIT];
    end else if (clr_en_i) begin
      en_q   <= 1'b0;
    end
  end

  always_comb begin
    ctrl_o = '0;
    ctrl_o[CTRL_MODE_LO +: 2] = mode_q;
    ctrl_o[CTRL_EN_BIT]       = en_q;
    ctrl_o[CTRL_POL_BIT]      = pol_q;
  end

  assign mode_o = mode_q;
  assign en_o   = en_q;
  assign pol_o  = pol_q;
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned DW     = 8,
  parameter int unsigned NBYTES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 step_i,
  input  logic [NBYTES-1:0]    wr_be_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [NBYTES*DW-1:0] cnt_o,
  output logic                 ovf_o
);
  localparam int unsigned CW = NBYTES * DW;

  logic [CW-1:0] pre_q, cnt_q, load_val;
  logic          ovf_q, at_max;

  generate
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)       pre_q[b*DW +: DW] <= '0;
        else if (wr_be_i[b]) pre_q[b*DW +: DW] <= wdata_i;
      assign load_val[b*DW +: DW] = wr_be_i[b] ? wdata_i : pre_q[b*DW +: DW];
    end
  endgenerate

  assign at_max = &cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= step_i & at_max;
      if (!en_i && |wr_be_i) cnt_q <= load_val;
      else if (step_i)       cnt_q <= at_max ? pre_q : cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import tmr_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    addr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  input  logic          pin_i,
  input  logic          tick_i,
  output logic          ovf_o
);
  localparam int unsigned NBYTES = 2;
  localparam int unsigned CW     = NBYTES * DW;

  tmr_mode_e     mode_w;
  logic          en_w, pol_w, lvl_w, hit_w, trail_w, freeze_w, step_w, clr_en_w;
  logic [DW-1:0] ctrl_w;
  logic [CW-1:0] cnt_w;
  logic [NBYTES-1:0] wr_be;

  tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .pin_i, .pol_i(pol_w),
    .lvl_o(lvl_w), .hit_o(hit_w), .trail_o(trail_w)
  );

  assign clr_en_w = (mode_w == MODE_PW) && en_w && trail_w;

  tmr_ctrl #(.DW(DW)) u_ctrl (
    .clk_i, .rst_ni,
    .wr_i(wr_i && addr_i == ADDR_CTRL),
    .wdata_i, .clr_en_i(clr_en_w),
    .mode_o(mode_w), .en_o(en_w), .pol_o(pol_w), .ctrl_o(ctrl_w)
  );

  assign freeze_w = rd_i && addr_i == ADDR_CNT_HI;

  always_comb begin
    unique case (mode_w)
      MODE_EVT: step_w = hit_w;
      MODE_TIM: step_w = tick_i;
      MODE_PW:  step_w = tick_i && (lvl_w ^ pol_w);
      default:  step_w = 1'b0;
    endcase
    step_w = step_w && en_w && !freeze_w;
  end

  assign wr_be = {wr_i && addr_i == ADDR_CNT_HI, wr_i && addr_i == ADDR_CNT_LO};

  tmr_count #(.DW(DW), .NBYTES(NBYTES)) u_cnt (
    .clk_i, .rst_ni, .en_i(en_w), .step_i(step_w),
    .wr_be_i(wr_be), .wdata_i, .cnt_o(cnt_w), .ovf_o
  );

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        ADDR_CTRL:   rdata_o = ctrl_w;
        ADDR_CNT_LO: rdata_o = cnt_w[DW-1:0];
        ADDR_CNT_HI: rdata_o = cnt_w[CW-1:DW];
        default:     rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    addr_i,
  input logic          wr_i,
  input logic          rd_i,
  input logic [DW-1:0] rdata_o,
  input logic          ovf_o,
  input logic [1:0]    mode,
  input logic          en,
  input logic          trail,
  input logic [CW-1:0] cnt
);
  // R2
  ctrl_zero_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 2'd0) |-> (rdata_o[2:0] == 3'b0 && rdata_o[5] == 1'b0));
  // R3
  disabled_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !wr_i) |=> $stable(cnt));
  // R6
  mode_off_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == 2'b00 && !wr_i) |=> $stable(cnt));
  // R7
  pw_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == 2'b11 && en && trail && !wr_i) |=> !en);
  // R9
  ovf_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> !ovf_o);
  // R9
  ovf_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(cnt) == {CW{1'b1}});
  // R11
  freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 2'd2 && !wr_i) |=> $stable(cnt));
endmodule

bind evt_timer evt_timer_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .rdata_o, .ovf_o,
  .mode(mode_w), .en(en_w), .trail(trail_w), .cnt(cnt_w)
);

// File: tb/sim_evt_timer.sv
`timescale 1ns/1ps
module sim_evt_timer;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0, pin = 1'b0, tick = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ovf;
  int         checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  evt_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rd_i(rd), .rdata_o(rdata), .pin_i(pin), .tick_i(tick), .ovf_o(ovf)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1; d = rdata; rd = 1'b0;
  endtask

  task automatic rd_cnt(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd_reg(2'd1, lo); rd_reg(2'd2, hi); v = {hi, lo};
  endtask

  task automatic load(input logic [7:0] ctrl_off, input logic [15:0] v);
    wr_reg(2'd0, ctrl_off);
    wr_reg(2'd1, v[7:0]);
    wr_reg(2'd2, v[15:8]);
  endtask

  task automatic pulses(input int n, input logic lvl);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pin = lvl;
      repeat (4) @(negedge clk);
      pin = ~lvl;
      repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d; logic [15:0] v;
    rd_reg(2'd0, d); chk("R1 ctrl", 16'(d), 16'h00);
    rd_cnt(v);       chk("R1 count", v, 16'h0000);
    chk("R1 ovf", 16'(ovf), 16'h0);
  endtask

  task automatic t_ctrl;
    logic [7:0] d;
    wr_reg(2'd0, 8'hFF); rd_reg(2'd0, d); chk("R2 readback FF", 16'(d), 16'hD8);
    wr_reg(2'd0, 8'h27); rd_reg(2'd0, d); chk("R2 readback 27", 16'(d), 16'h00);
    rd_reg(2'd3, d); chk("R2 addr3", 16'(d), 16'h00);
    @(negedge clk); addr = 2'd0; #1; chk("R2 idle rdata", 16'(rdata), 16'h00);
  endtask

  task automatic t_timer;
    logic [15:0] v;
    load(8'h80, 16'h0000);
    wr_reg(2'd0, 8'h90);
    @(negedge clk); tick = 1'b1;
    repeat (10) @(negedge clk);
    tick = 1'b0;
    rd_cnt(v); chk("R3 tick count", v, 16'd10);
    wr_reg(2'd0, 8'h80);
    tick = 1'b1; repeat (5) @(negedge clk); tick = 1'b0;
    rd_cnt(v); chk("R3 disabled hold", v, 16'd10);
  endtask

  task automatic t_event;
    logic [15:0] v;
    load(8'h40, 16'h0000);
    wr_reg(2'd0, 8'h50);
    pulses(3, 1'b1);
    rd_cnt(v); chk("R4 rising edges", v, 16'd3);
    load(8'h48, 16'h0000);
    wr_reg(2'd0, 8'h58);
    pulses(2, 1'b1);
    rd_cnt(v); chk("R5 falling edges", v, 16'd2);
  endtask

  task automatic t_off;
    logic [15:0] v;
    load(8'h00, 16'h0055);
    wr_reg(2'd0, 8'h10);
    tick = 1'b1;
    pulses(2, 1'b1);
    tick = 1'b0;
    rd_cnt(v); chk("R6 mode off", v, 16'h0055);
  endtask

  task automatic t_pw;
    logic [15:0] v; logic [7:0] d;
    load(8'hC0, 16'h0000);
    wr_reg(2'd0, 8'hD0);
    tick = 1'b1;
    @(negedge clk); pin = 1'b1;
    repeat (6) @(negedge clk); pin = 1'b0;
    repeat (6) @(negedge clk);
    pin = 1'b1; repeat (6) @(negedge clk); pin = 1'b0; repeat (6) @(negedge clk);
    tick = 1'b0;
    rd_cnt(v); chk("R7 high width", v, 16'd6);
    rd_reg(2'd0, d); chk("R7 enable cleared", 16'(d), 16'hC0);
    // low-active: park pin high first
    pin = 1'b1; repeat (6) @(negedge clk);
    load(8'hC8, 16'h0000);
    wr_reg(2'd0, 8'hD8);
    tick = 1'b1;
    @(negedge clk); pin = 1'b0;
    repeat (4) @(negedge clk); pin = 1'b1;
    repeat (6) @(negedge clk);
    pin = 1'b0; repeat (4) @(negedge clk); pin = 1'b1; repeat (6) @(negedge clk);
    tick = 1'b0;
    rd_cnt(v); chk("R8 low width", v, 16'd4);
    rd_reg(2'd0, d); chk("R8 enable cleared", 16'(d), 16'hC8);
    pin = 1'b0; repeat (6) @(negedge clk);
  endtask

  task automatic t_ovf;
    logic [15:0] v;
    load(8'h80, 16'hFFFF);
    rd_cnt(v); chk("R10 load while disabled", v, 16'hFFFF);
    wr_reg(2'd0, 8'h90);
    wr_reg(2'd1, 8'h34);
    wr_reg(2'd2, 8'h12);
    rd_cnt(v); chk("R10 no load while enabled", v, 16'hFFFF);
    chk("R9 ovf idle", 16'(ovf), 16'h0);
    @(negedge clk); tick = 1'b1;
    @(posedge clk); #1; tick = 1'b0;
    chk("R9 ovf pulse", 16'(ovf), 16'h1);
    @(negedge clk); addr = 2'd1; rd = 1'b1; #1;
    chk("R9 reload low", 16'(rdata), 16'h34);
    rd = 1'b0;
    @(posedge clk); #1; chk("R9 ovf one cycle", 16'(ovf), 16'h0);
    rd_cnt(v); chk("R9 reload value", v, 16'h1234);
  endtask

  task automatic t_freeze;
    logic [15:0] v;
    load(8'h80, 16'h0000);
    wr_reg(2'd0, 8'h90);
    @(negedge clk); tick = 1'b1;
    repeat (2) @(negedge clk);
    addr = 2'd2; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    repeat (2) @(negedge clk);
    tick = 1'b0;
    rd_cnt(v); chk("R11 freeze loses one", v, 16'd4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_timer();
    t_event();
    t_off();
    t_pw();
    t_ovf();
    t_freeze();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule